// File: doc/BRIEF.md
# Bit-Walking RAM Self-Test Controller

This block is a built-in self-test engine for one single-port synchronous RAM. The RAM's width and depth are set by parameters. A start pulse launches a three-phase test. The first phase clears every word. The second phase climbs through the address space. At each word it checks that the word is still zero, then sets the bits one at a time from bit 0 upward. The third phase descends through the address space. At each word it checks that the word is all ones, then clears the bits one at a time from bit 0 upward. After every single-bit write the engine reads the word back. It compares the result with the exact cumulative pattern expected at that step.

The test is aimed at three kinds of fault. Address lines that are shorted or stuck show up as writes landing on other words. Data lines that are shorted or stuck show up as bits that cannot be set or cleared. Cells that lose their contents also show up. When the first mismatch is seen the engine stops and records the failing address, the expected word and the word actually read. A clean run ends with a pass verdict. The verdict and the recorded values stay on the outputs until the next start.

Top module: `bitmarch_bist`

## Requirements
- R1: After start, the engine first writes 0 to every address, in order from 0 up to the highest address, with one write per cycle.
- R2: In the rising phase the addresses are visited from 0 up to the highest. Each word is read once before any bit is written to it, and that read is expected to be 0.
- R3: In the rising phase, step k writes the word with bits 0 through k set and the other bits clear. The word is then read back and compared with that same pattern. This repeats for k from 0 to DW-1.
- R4: In the falling phase the addresses are visited from the highest down to 0. Each word is first read and expected to be all ones.
- R5: In the falling phase, step k writes the word with bits 0 through k clear and the other bits set. The word is then read back and compared with that pattern. The last step leaves the word at 0.
- R6: The RAM has one cycle of read latency. Write enable and read enable are never high in the same cycle. Every read is issued in a cycle after the write it checks, and the cycle after a read never issues a read. A full run makes 2^AW·(1+2·DW) writes and 2^AW·2·(DW+1) reads.
- R7: On the first mismatch the engine stops in the cycle after the compare. It raises done and fail, and it holds the failing address, the expected word and the actual word.
- R8: pass is raised together with done only when all three phases finish without a mismatch. A clean run keeps busy high for exactly 2^AW·(1+2·(2+3·DW)) cycles. When done is high, exactly one of pass and fail is high.
- R9: A start pulse while busy is ignored. done, pass, fail and the recorded values hold until the next start. A start clears them all to 0.
- R10: After reset, busy, done, pass, fail, write enable and read enable are low, and the recorded address, expected word and actual word are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that launches a test when the engine is not busy |
| mem_rdata | input | DW | Read data from the RAM, valid one cycle after mem_re |
| mem_addr | output | AW | RAM address |
| mem_wdata | output | DW | RAM write data |
| mem_we | output | 1 | RAM write enable |
| mem_re | output | 1 | RAM read enable |
| busy | output | 1 | Test in progress |
| done | output | 1 | Test finished, verdict valid |
| pass | output | 1 | Test finished with no mismatch |
| fail | output | 1 | Test stopped on a mismatch |
| fail_addr | output | AW | Address of the first mismatch |
| fail_exp | output | DW | Expected word at the first mismatch |
| fail_act | output | DW | Word read at the first mismatch |

## Verification
Each word costs a fixed number of cycles: a pre-read and compare pair, then a write, read and compare triple for every bit. This makes the cycle in which a test ends computable in advance. Without faults it ends 2^AW·53 cycles after start at the default size. With a fault, the end cycle follows from the failing address and bit. The bench counts the cycles in which busy is high, sampling on the falling edge. It compares that count with the figure worked out from these rules, then reads the verdict and recorded values at the first falling edge where busy is low. The bench RAM model applies write data at the rising edge and returns read data one edge later. The bench logs every write as it happens, so the address order and cumulative patterns are checked against indices computed from the phase layout.

// File: rtl/bitmarch_pkg.sv
package bitmarch_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INIT,
    ST_PRE_RD,
    ST_PRE_CMP,
    ST_BIT_WR,
    ST_BIT_RD,
    ST_BIT_CMP,
    ST_DONE
  } state_t;

  typedef enum logic {
    DIR_UP,
    DIR_DOWN
  } dir_t;
endpackage

// File: rtl/bitmarch_addr_seq.sv
module bitmarch_addr_seq #(
  parameter int AW = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_lo,
  input  logic                load_hi,
  input  logic                step,
  input  bitmarch_pkg::dir_t  dir,
  output logic [AW-1:0]       addr,
  output logic                at_end
);
  import bitmarch_pkg::*;

  localparam logic [AW-1:0] ADDR_MAX = '1;

  logic [AW-1:0] addr_nxt;
  logic          addr_en;

  always_comb begin
    addr_en  = load_lo | load_hi | step;
    addr_nxt = addr;
    if (load_lo) begin
      addr_nxt = '0;
    end else if (load_hi) begin
      addr_nxt = ADDR_MAX;
    end else if (step) begin
      if (dir == DIR_UP) addr_nxt = addr + 1'b1;
      else               addr_nxt = addr - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr <= '0;
    else if (addr_en) addr <= addr_nxt;
  end

  assign at_end = (dir == DIR_UP) ? (addr == ADDR_MAX) : (addr == '0);
endmodule

// File: rtl/bitmarch_pattern.sv
module bitmarch_pattern #(
  parameter int DW = 8,
  parameter int BW = 3
) (
  input  bitmarch_pkg::dir_t  dir,
  input  logic                pre_chk,
  input  logic [BW-1:0]       bit_idx,
  output logic [DW-1:0]       exp_word
);
  import bitmarch_pkg::*;

  // thru[i] is one for every bit position at or below the current step
  logic [DW-1:0] thru;

  for (genvar i = 0; i < DW; i++) begin : g_thru
    localparam logic [BW-1:0] POS = BW'(i);
    assign thru[i] = (POS <= bit_idx);
  end

  always_comb begin
    if (dir == DIR_UP) exp_word = pre_chk ? '0 : thru;
    else               exp_word = pre_chk ? '1 : ~thru;
  end
endmodule

// File: rtl/bitmarch_result.sv
module bitmarch_result #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          capture,
  input  logic          set_pass,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] exp_word,
  input  logic [DW-1:0] act_word,
  output logic          pass,
  output logic          fail,
  output logic [AW-1:0] fail_addr,
  output logic [DW-1:0] fail_exp,
  output logic [DW-1:0] fail_act
);
  logic          res_en;
  logic          pass_nxt;
  logic          fail_nxt;
  logic [AW-1:0] addr_nxt;
  logic [DW-1:0] exp_nxt;
  logic [DW-1:0] act_nxt;

  always_comb begin
    res_en   = clear | capture | set_pass;
    pass_nxt = pass;
    fail_nxt = fail;
    addr_nxt = fail_addr;
    exp_nxt  = fail_exp;
    act_nxt  = fail_act;
    if (clear) begin
      pass_nxt = 1'b0;
      fail_nxt = 1'b0;
      addr_nxt = '0;
      exp_nxt  = '0;
      act_nxt  = '0;
    end else if (capture) begin
      fail_nxt = 1'b1;
      addr_nxt = addr;
      exp_nxt  = exp_word;
      act_nxt  = act_word;
    end else if (set_pass) begin
      pass_nxt = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pass      <= 1'b0;
      fail      <= 1'b0;
      fail_addr <= '0;
      fail_exp  <= '0;
      fail_act  <= '0;
    end else if (res_en) begin
      pass      <= pass_nxt;
      fail      <= fail_nxt;
      fail_addr <= addr_nxt;
      fail_exp  <= exp_nxt;
      fail_act  <= act_nxt;
    end
  end
endmodule

// File: rtl/bitmarch_bist.sv
module bitmarch_bist #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  output logic          mem_re,
  output logic          busy,
  output logic          done,
  output logic          pass,
  output logic          fail,
  output logic [AW-1:0] fail_addr,
  output logic [DW-1:0] fail_exp,
  output logic [DW-1:0] fail_act
);
  import bitmarch_pkg::*;

  localparam int BW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [BW-1:0] LAST_BIT = BW'(DW - 1);

  state_t        state, state_nxt;
  dir_t          dir, dir_nxt;
  logic [BW-1:0] bit_idx, bit_nxt;
  logic          ctl_en;

  logic          ld_lo, ld_hi, a_step, a_end;
  logic          res_clr, res_cap, res_pass;
  logic          pre_chk, mismatch;
  logic [DW-1:0] exp_word;

  bitmarch_addr_seq #(.AW(AW)) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_lo (ld_lo),
    .load_hi (ld_hi),
    .step    (a_step),
    .dir     (dir),
    .addr    (mem_addr),
    .at_end  (a_end)
  );

  bitmarch_pattern #(.DW(DW), .BW(BW)) u_pat (
    .dir      (dir),
    .pre_chk  (pre_chk),
    .bit_idx  (bit_idx),
    .exp_word (exp_word)
  );

  bitmarch_result #(.AW(AW), .DW(DW)) u_res (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (res_clr),
    .capture   (res_cap),
    .set_pass  (res_pass),
    .addr      (mem_addr),
    .exp_word  (exp_word),
    .act_word  (mem_rdata),
    .pass      (pass),
    .fail      (fail),
    .fail_addr (fail_addr),
    .fail_exp  (fail_exp),
    .fail_act  (fail_act)
  );

  assign pre_chk  = (state == ST_PRE_CMP);
  assign mismatch = (mem_rdata != exp_word);

  // next-state and control decode
  always_comb begin
    state_nxt = state;
    dir_nxt   = dir;
    bit_nxt   = bit_idx;
    ld_lo     = 1'b0;
    ld_hi     = 1'b0;
    a_step    = 1'b0;
    res_clr   = 1'b0;
    res_cap   = 1'b0;
    res_pass  = 1'b0;
    mem_we    = 1'b0;
    mem_re    = 1'b0;
    mem_wdata = '0;

    unique case (state)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          state_nxt = ST_INIT;
          dir_nxt   = DIR_UP;
          bit_nxt   = '0;
          ld_lo     = 1'b1;
          res_clr   = 1'b1;
        end
      end
      ST_INIT: begin
        mem_we = 1'b1;
        if (a_end) begin
          state_nxt = ST_PRE_RD;
          ld_lo     = 1'b1;
        end else begin
          a_step = 1'b1;
        end
      end
      ST_PRE_RD: begin
        mem_re    = 1'b1;
        state_nxt = ST_PRE_CMP;
      end
      ST_PRE_CMP: begin
        if (mismatch) begin
          res_cap   = 1'b1;
          state_nxt = ST_DONE;
        end else begin
          bit_nxt   = '0;
          state_nxt = ST_BIT_WR;
        end
      end
      ST_BIT_WR: begin
        mem_we    = 1'b1;
        mem_wdata = exp_word;
        state_nxt = ST_BIT_RD;
      end
      ST_BIT_RD: begin
        mem_re    = 1'b1;
        state_nxt = ST_BIT_CMP;
      end
      ST_BIT_CMP: begin
        if (mismatch) begin
          res_cap   = 1'b1;
          state_nxt = ST_DONE;
        end else if (bit_idx != LAST_BIT) begin
          bit_nxt   = bit_idx + 1'b1;
          state_nxt = ST_BIT_WR;
        end else if (!a_end) begin
          a_step    = 1'b1;
          state_nxt = ST_PRE_RD;
        end else if (dir == DIR_UP) begin
          dir_nxt   = DIR_DOWN;
          ld_hi     = 1'b1;
          state_nxt = ST_PRE_RD;
        end else begin
          res_pass  = 1'b1;
          state_nxt = ST_DONE;
        end
      end
      default: state_nxt = ST_IDLE;
    endcase
  end

  assign ctl_en = (state_nxt != state) || (dir_nxt != dir) || (bit_nxt != bit_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      dir     <= DIR_UP;
      bit_idx <= '0;
    end else if (ctl_en) begin
      state   <= state_nxt;
      dir     <= dir_nxt;
      bit_idx <= bit_nxt;
    end
  end

  assign busy = (state != ST_IDLE) && (state != ST_DONE);
  assign done = (state == ST_DONE);
endmodule

// File: rtl/bitmarch_bist_checker.sv
module bitmarch_bist_checker #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          mem_we,
  input logic          mem_re,
  input logic          busy,
  input logic          done,
  input logic          pass,
  input logic          fail,
  input logic [AW-1:0] fail_addr,
  input logic [DW-1:0] fail_exp,
  input logic [DW-1:0] fail_act
);
  // R6: a cycle never both reads and writes
  assert_rw_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_re && mem_we));

  // R6: each read is followed by a compare cycle, never a second read
  assert_read_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> !mem_re);

  // R9: start while busy does not disturb the run
  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> busy);

  // R9: verdict and record hold until the next start
  assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(pass) && $stable(fail) &&
                          $stable(fail_addr) && $stable(fail_exp) && $stable(fail_act)));

  // R8: a finished test carries exactly one verdict
  assert_one_verdict_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pass != fail));

  // R7: a recorded failure means the engine has stopped
  assert_fail_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> (done && !busy));

  // R10: no RAM traffic outside a run
  assert_quiet_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_we && !mem_re));
endmodule

bind bitmarch_bist bitmarch_bist_checker #(.AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .mem_we    (mem_we),
  .mem_re    (mem_re),
  .busy      (busy),
  .done      (done),
  .pass      (pass),
  .fail      (fail),
  .fail_addr (fail_addr),
  .fail_exp  (fail_exp),
  .fail_act  (fail_act)
);

// File: tb/bitmarch_bist_bench.sv
`timescale 1ns/1ps
module bitmarch_bist_bench;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int N  = 1 << AW;
  localparam int PER_WORD = 2 + 3 * DW;
  localparam int RUN_CYC  = N * (1 + 2 * PER_WORD);
  localparam int N_WR     = N * (1 + 2 * DW);
  localparam int N_RD     = N * 2 * (DW + 1);

  logic          clk;
  logic          rst_n;
  logic          start;
  logic [DW-1:0] mem_rdata;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          mem_we, mem_re;
  logic          busy, done, pass, fail;
  logic [AW-1:0] fail_addr;
  logic [DW-1:0] fail_exp, fail_act;

  int checks = 0;
  int errors = 0;

  bitmarch_bist #(.AW(AW), .DW(DW)) u_bitmarch_bist (
    .clk(clk), .rst_n(rst_n), .start(start), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .busy(busy), .done(done), .pass(pass), .fail(fail),
    .fail_addr(fail_addr), .fail_exp(fail_exp), .fail_act(fail_act)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // RAM model with injectable faults
  logic [DW-1:0] mem [0:N-1];
  logic [AW-1:0] st_addr;
  logic [DW-1:0] st0_mask, st1_mask;
  logic          al_en;
  logic [AW-1:0] al_src, al_dst;

  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
      if (al_en && mem_addr == al_src) mem[al_dst] <= mem_wdata;
    end
    if (mem_re) begin
      if (mem_addr == st_addr) mem_rdata <= (mem[mem_addr] & ~st0_mask) | st1_mask;
      else                     mem_rdata <= mem[mem_addr];
    end
  end

  // write log
  logic [AW-1:0] wa [0:N_WR-1];
  logic [DW-1:0] wd [0:N_WR-1];
  int nw, nr;

  always @(posedge clk) begin
    if (mem_we) begin
      if (nw < N_WR) begin
        wa[nw] <= mem_addr;
        wd[nw] <= mem_wdata;
      end
      nw <= nw + 1;
    end
    if (mem_re) nr <= nr + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_faults();
    st_addr  = '0;
    st0_mask = '0;
    st1_mask = '0;
    al_en    = 1'b0;
    al_src   = '0;
    al_dst   = '0;
  endtask

  // start a run; optionally pulse start again at busy cycle extra_at
  task automatic run(input int extra_at, output int cyc);
    @(negedge clk);
    nw = 0;
    nr = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (busy && cyc < 5000) begin
      cyc++;
      start = (cyc == extra_at);
      @(negedge clk);
    end
    start = 1'b0;
    if (cyc >= 5000) chk("R8 run ended", 0, 1);
  endtask

  task automatic t_reset();
    chk("R10 busy", busy, 0);
    chk("R10 done", done, 0);
    chk("R10 pass", pass, 0);
    chk("R10 fail", fail, 0);
    chk("R10 we/re", {mem_we, mem_re}, 0);
    chk("R10 record", {fail_addr, fail_exp, fail_act}, 0);
  endtask

  task automatic t_clean();
    int cyc;
    bit ok;
    clear_faults();
    run(0, cyc);
    chk("R8 run length", cyc, RUN_CYC);
    chk("R8 pass", pass, 1);
    chk("R8 fail", fail, 0);
    chk("R8 done", done, 1);
    chk("R6 write count", nw, N_WR);
    chk("R6 read count", nr, N_RD);
    ok = 1;
    for (int i = 0; i < N; i++) if (wa[i] != AW'(i) || wd[i] != '0) ok = 0;
    chk("R1 zero fill order", ok, 1);
    ok = 1;
    for (int a = 0; a < N; a++)
      for (int k = 0; k < DW; k++)
        if (wa[N + a*DW + k] != AW'(a) || wd[N + a*DW + k] != DW'((1 << (k+1)) - 1)) ok = 0;
    chk("R2 R3 rising order and patterns", ok, 1);
    ok = 1;
    for (int j = 0; j < N; j++)
      for (int k = 0; k < DW; k++)
        if (wa[N + N*DW + j*DW + k] != AW'(N-1-j) ||
            wd[N + N*DW + j*DW + k] != ~DW'((1 << (k+1)) - 1)) ok = 0;
    chk("R4 R5 falling order and patterns", ok, 1);
    chk("R5 last write word", wd[N_WR-1], 0);
    repeat (20) @(negedge clk);
    chk("R9 held done", done, 1);
    chk("R9 held pass", pass, 1);
  endtask

  task automatic t_stuck0();
    int cyc;
    clear_faults();
    st_addr = 5; st0_mask = 8'h08;
    run(0, cyc);
    chk("R7 stop cycle", cyc, N + 5*PER_WORD + 2 + 3*4);
    chk("R7 fail", {done, fail, pass}, 3'b110);
    chk("R7 fail_addr", fail_addr, 5);
    chk("R3 fail_exp", fail_exp, 8'h0F);
    chk("R3 fail_act", fail_act, 8'h07);
  endtask

  task automatic t_stuck1();
    int cyc;
    clear_faults();
    st_addr = 9; st1_mask = 8'h04;
    run(0, cyc);
    chk("R2 stop cycle", cyc, N + 9*PER_WORD + 2);
    chk("R2 fail_addr", fail_addr, 9);
    chk("R2 exp/act", {fail_exp, fail_act}, 16'h0004);
  endtask

  task automatic t_alias_up();
    int cyc;
    clear_faults();
    al_en = 1; al_src = 3; al_dst = 11;
    run(0, cyc);
    chk("R2 alias stop cycle", cyc, N + 11*PER_WORD + 2);
    chk("R2 alias fail_addr", fail_addr, 11);
    chk("R2 alias exp/act", {fail_exp, fail_act}, 16'h00FF);
  endtask

  task automatic t_alias_down();
    int cyc;
    clear_faults();
    al_en = 1; al_src = 11; al_dst = 3;
    run(0, cyc);
    chk("R4 alias stop cycle", cyc, N + N*PER_WORD + 12*PER_WORD + 2);
    chk("R4 alias fail_addr", fail_addr, 3);
    chk("R4 alias exp/act", {fail_exp, fail_act}, 16'hFF00);
    chk("R7 verdict", {done, fail, pass}, 3'b110);
  endtask

  task automatic t_busy_start();
    int cyc;
    clear_faults();
    run(100, cyc);
    chk("R9 start while busy run length", cyc, RUN_CYC);
    chk("R9 start while busy pass", pass, 1);
    chk("R9 restart cleared record", {fail, fail_addr, fail_exp, fail_act}, 0);
  endtask

  task automatic t_start_clears();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9 start clears verdict", {done, fail, pass}, 0);
    chk("R9 start clears record", {fail_addr, fail_exp, fail_act}, 0);
    while (busy) @(negedge clk);
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    start = 1'b0;
    nw = 0;
    nr = 0;
    clear_faults();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_clean();
    t_stuck0();
    t_stuck1();
    t_alias_up();
    t_start_clears();
    t_alias_down();
    t_busy_start();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule